// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a clocked master that reads one 14-bit result from a serial-output analog-to-digital converter each time a user pulses `start`. It pulls an active-low chip select low, generates a serial clock by dividing the system clock, captures the converter's data line on every serial-clock rising edge, and then releases chip select. The 14-bit word comes back with a one-cycle valid strobe and a framing-error flag.

Each frame is exactly 18 serial clocks long. On the wire, the frame carries two leading zero bits, then the 14 result bits MSB first, then two trailing zero bits. The converter changes its data after each falling serial-clock edge, so the reader samples on the rising edge. The serial-clock half-period is taken from a divider input and clamped to the range the converter accepts. After each frame, chip select is held high for a minimum gap before another frame can begin. `busy` covers the frame and that gap.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, and whenever `busy` is low, `adc_cs_n` is 1, `adc_sclk` is 0, `busy` is 0 and `valid` is 0.
- R2: A `start` seen while idle begins a frame in the next cycle. `adc_cs_n` goes low with `adc_sclk` low, and exactly 18 rising edges of `adc_sclk` follow, all while `adc_cs_n` is low.
- R3: Each `adc_sclk` phase, high or low, lasts H system cycles, with H = `div_sel` clamped to [18, 111]. With the default 5 ns clock this keeps each phase at 90 ns or more and the period at 1110 ns or less. The first rising edge comes H cycles after `adc_cs_n` falls.
- R4: The data line is sampled on each `adc_sclk` rising edge. Frame bits are numbered 1..18 in arrival order, and `result[13:0]` holds bits 3..16 with bit 3 as result[13]. The result is a two's-complement code passed through unchanged.
- R5: `valid` is high for exactly one cycle. It rises in the cycle that `adc_cs_n` returns high, which is the same cycle as the 18th falling edge of `adc_sclk`, 36·H cycles after `adc_cs_n` fell.
- R6: `frame_err` is set with `valid` when any of frame bits 1, 2, 17 or 18 was 1, and is cleared with `valid` otherwise.
- R7: After a frame, `adc_cs_n` stays high for at least 4 cycles (20 ns). `busy` rises one cycle after an accepted `start` and stays high until 36·H+4 cycles after it.
- R8: A `start` seen while `busy` is high is ignored. The frame in progress keeps its timing, and no extra frame is launched.
- R9: `result` and `frame_err` hold their values from one `valid` to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion read |
| div_sel | input | 8 | Requested serial-clock half-period in system cycles |
| busy | output | 1 | Frame or chip-select gap in progress |
| result | output | 14 | Last received result, two's complement |
| valid | output | 1 | One-cycle strobe for a new result |
| frame_err | output | 1 | Leading or trailing frame bits were not zero |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_sdata | input | 1 | Converter serial data |

## Verification
The completion of a frame (valid, result load and chip-select release) can fall in the same cycle as a new start request, and start requests can also keep arriving while the chip-select gap is being counted. The bench holds `start` high from the middle of one frame, through its completion cycle and the whole gap. A behavioural model compares every output on every cycle and must see the second frame begin only on the first idle cycle. The bench also counts chip-select falls against accepted starts, so that a spurious relaunch is caught.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_GAP  = 2'd3
  } rd_state_e;

  // Bound a requested half-period into the legal window.
  function automatic int clamp_half(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Ceiling division used to turn nanosecond limits into cycle counts.
  function automatic int ns_to_cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FRAME_LEN = 18,
  parameter int LEAD_W    = 2,
  parameter int DATA_W    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              din,
  output logic [DATA_W-1:0] word,
  output logic              bad
);
  localparam int TRAIL_W = FRAME_LEN - LEAD_W - DATA_W;

  logic [FRAME_LEN-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '0;
    else if (clr) sh_q <= '0;
    else if (cap) sh_q <= {sh_q[FRAME_LEN-2:0], din};
  end

  assign word = sh_q[FRAME_LEN-LEAD_W-1 -: DATA_W];
  assign bad  = (|sh_q[FRAME_LEN-1 -: LEAD_W]) | (|sh_q[TRAIL_W-1:0]);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W             = 14,
  parameter int LEAD_W             = 2,
  parameter int FRAME_LEN          = 18,
  parameter int DIV_W              = 8,
  parameter int CLK_NS             = 5,
  parameter int SCLK_MIN_PHASE_NS  = 89,
  parameter int SCLK_MAX_PERIOD_NS = 1111,
  parameter int CS_GAP_NS          = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  div_sel,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              frame_err,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sdata
);
  localparam int MIN_HALF = ns_to_cyc_ceil(SCLK_MIN_PHASE_NS, CLK_NS);
  localparam int MAX_HALF = (SCLK_MAX_PERIOD_NS / 2) / CLK_NS;
  localparam int GAP_CYC  = (ns_to_cyc_ceil(CS_GAP_NS, CLK_NS) < 1) ? 1
                           : ns_to_cyc_ceil(CS_GAP_NS, CLK_NS);
  localparam int CNT_W    = $clog2(FRAME_LEN + 1);
  localparam int GAP_W    = $clog2(GAP_CYC + 1);

  rd_state_e         state_q;
  logic [DIV_W-1:0]  half_q;
  logic [DIV_W-1:0]  half_sel;
  logic [CNT_W-1:0]  edge_cnt_q;
  logic [GAP_W-1:0]  gap_cnt_q;
  logic              cs_n_q, sclk_q, valid_q, err_q;
  logic [DATA_W-1:0] result_q;
  logic              tick;
  logic [DATA_W-1:0] sh_word;
  logic              sh_bad;

  // Named internal events
  logic start_ok, rise_ev, fall_ev, last_fall, gap_done, run;

  assign half_sel  = DIV_W'(clamp_half(int'(div_sel), MIN_HALF, MAX_HALF));
  assign run       = (state_q == ST_LO) || (state_q == ST_HI);
  assign start_ok  = start && (state_q == ST_IDLE);
  assign rise_ev   = tick && (state_q == ST_LO);
  assign fall_ev   = tick && (state_q == ST_HI);
  assign last_fall = fall_ev && (edge_cnt_q == CNT_W'(FRAME_LEN));
  assign gap_done  = (state_q == ST_GAP) && (gap_cnt_q == GAP_W'(GAP_CYC - 1));

  adc_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .half (half_q),
    .tick (tick)
  );

  adc_rd_shift #(.FRAME_LEN(FRAME_LEN), .LEAD_W(LEAD_W), .DATA_W(DATA_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_ok),
    .cap  (rise_ev),
    .din  (adc_sdata),
    .word (sh_word),
    .bad  (sh_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      half_q     <= DIV_W'(MIN_HALF);
      edge_cnt_q <= '0;
      gap_cnt_q  <= '0;
      cs_n_q     <= 1'b1;
      sclk_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q    <= ST_LO;
          half_q     <= half_sel;
          edge_cnt_q <= '0;
          cs_n_q     <= 1'b0;
        end
        ST_LO: if (rise_ev) begin
          state_q    <= ST_HI;
          sclk_q     <= 1'b1;
          edge_cnt_q <= edge_cnt_q + 1'b1;
        end
        ST_HI: if (fall_ev) begin
          sclk_q <= 1'b0;
          if (last_fall) begin
            state_q   <= ST_GAP;
            cs_n_q    <= 1'b1;
            gap_cnt_q <= '0;
          end else begin
            state_q <= ST_LO;
          end
        end
        ST_GAP: begin
          if (gap_done) state_q <= ST_IDLE;
          else          gap_cnt_q <= gap_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= last_fall;
      if (last_fall) begin
        result_q <= sh_word;
        err_q    <= sh_bad;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign result    = result_q;
  assign valid     = valid_q;
  assign frame_err = err_q;
  assign adc_cs_n  = cs_n_q;
  assign adc_sclk  = sclk_q;
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int MIN_HALF = 18,
  parameter int GAP_CYC  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic valid,
  input logic adc_cs_n,
  input logic adc_sclk
);
  logic        sclk_prev;
  logic [15:0] same_cnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      same_cnt  <= 16'(MIN_HALF);
      hi_cnt    <= 16'(GAP_CYC);
    end else begin
      sclk_prev <= adc_sclk;
      if (adc_sclk != sclk_prev)  same_cnt <= 16'd1;
      else if (same_cnt != '1)    same_cnt <= same_cnt + 16'd1;
      if (!adc_cs_n)              hi_cnt <= '0;
      else if (hi_cnt != '1)      hi_cnt <= hi_cnt + 16'd1;
    end
  end

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (adc_cs_n && !adc_sclk && !valid)); // R1
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n); // R2
  AST_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk != sclk_prev) |-> (same_cnt >= 16'(MIN_HALF))); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R5
  AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(adc_cs_n)); // R5
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= 16'(GAP_CYC))); // R7
  AST_GAP_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adc_cs_n && start) |=> adc_cs_n); // R8
endmodule

bind adc_frame_reader adc_rd_checker #(.MIN_HALF(MIN_HALF), .GAP_CYC(GAP_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .valid   (valid),
  .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk)
);

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  div_sel = 8'd20;
  logic        busy, valid, frame_err, adc_cs_n, adc_sclk;
  logic [13:0] result;
  logic        adc_sdata = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  adc_frame_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .div_sel(div_sel),
    .busy(busy), .result(result), .valid(valid), .frame_err(frame_err),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // Converter model: 18-bit frame, first bit driven at chip-select fall,
  // next bit after each serial-clock falling edge.
  logic [17:0] fvec = '0;
  int idx = 0;
  int rises = 0;
  int cs_falls = 0;
  always @(negedge adc_cs_n) begin
    idx = 0; rises = 0; cs_falls++;
    #1 adc_sdata = fvec[17];
  end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    idx++;
    #1 adc_sdata = (idx < 18) ? fvec[17-idx] : 1'b0;
  end
  always @(posedge adc_sclk) rises++;

  // Behavioural reference: t counts edges since an accepted start.
  int t = -1, h = 18, starts_model = 0;
  logic [13:0] exp_word = '0;
  logic        exp_err = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) t = -1;
    else if (t < 0) begin
      if (start) begin
        t = 0;
        h = (div_sel < 18) ? 18 : ((div_sel > 111) ? 111 : int'(div_sel));
        starts_model++;
      end
    end else if (t + 1 >= 36*h + GAP) t = -1;
    else t++;
    if (t == 36*h) begin
      exp_word = fvec[15:2];
      exp_err  = fvec[17] | fvec[16] | fvec[1] | fvec[0];
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit in_frame;
    in_frame = (t >= 0) && (t < 36*h);
    chk(adc_cs_n == !in_frame, "R2 cs_n", adc_cs_n, !in_frame);
    chk(adc_sclk == (in_frame && ((t/h) % 2 == 1)), "R3 sclk phase", adc_sclk,
        in_frame && ((t/h) % 2 == 1));
    chk(busy == (t >= 0), "R7 busy", busy, t >= 0);
    chk(valid == (t == 36*h), "R5 valid", valid, t == 36*h);
    if (valid) begin
      chk(rises == 18, "R2 rising edges per frame", rises, 18);
      chk(result == exp_word, "R4 result", result, exp_word);
      chk(frame_err == exp_err, "R6 frame_err", frame_err, exp_err);
    end else begin
      chk(result == exp_word, "R9 result hold", result, exp_word);
      chk(frame_err == exp_err, "R9 frame_err hold", frame_err, exp_err);
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (t >= 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] lead,
                       input logic [13:0] w, input logic [1:0] trail);
    div_sel = d;
    fvec = {lead, w, trail};
    pulse_start();
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n && !adc_sclk && !busy && !valid, "R1 reset idle state",
        {adc_cs_n, adc_sclk, busy, valid}, 4'b1000);

    frame(8'd20,  2'b00, 14'h2A5C, 2'b00);   // R3 in-range divider
    frame(8'd3,   2'b00, 14'h3FFF, 2'b00);   // R3 clamp to 18
    frame(8'd200, 2'b00, 14'h0000, 2'b00);   // R3 clamp to 111
    frame(8'd18,  2'b01, 14'h1234, 2'b00);   // R6 leading bit set
    frame(8'd19,  2'b00, 14'h2001, 2'b10);   // R6 trailing bit set
    frame(8'd18,  2'b00, 14'h0155, 2'b00);   // R6 clean frame clears flag

    // R8: start pulses mid-frame, then start held through completion and gap.
    div_sel = 8'd18;
    fvec = {2'b00, 14'h1A0F, 2'b00};
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (200) @(negedge clk);
    start = 1'b1;
    while (starts_model < 8) @(negedge clk);
    start = 1'b0;
    fvec = {2'b00, 14'h2222, 2'b00};
    wait_idle();
    chk(cs_falls == starts_model, "R8 frames launched", cs_falls, starts_model);
    chk(starts_model == 8, "R8 accepted starts", starts_model, 8);
    chk(adc_cs_n && !adc_sclk && !busy, "R1 idle after run",
        {adc_cs_n, adc_sclk, busy}, 3'b100);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule